// File: doc/BRIEF.md
# Structured-Sparsity Operand Expander

This block sits in front of a matrix engine and turns compressed sparse weight groups back into dense groups. Each compressed group stores only the values that survived pruning, and a small metadata field says where they belong. The expander puts each stored value at its dense position and fills every other position with zero. It also checks that the metadata describes a legal pattern, and it moves groups through a valid/ready stream without reordering them.

Two sparsity patterns are supported and can be selected per beat. In the element mode, a group has four 8-bit positions, and two of them carry stored values. In the pair mode, a group has eight 4-bit positions organised as four adjacent pairs. Two whole pairs carry stored values and the other two pairs are zero. Either way a compressed group is half the size of its dense form: 16 stored bits become 32 dense bits. One beat carries `LANES` independent groups, all in the same mode. The output is registered, so the latency is one cycle and the block accepts one beat per cycle while the consumer keeps up.

Top module: `sparse_expander`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and `in_ready` is 1.
- R2: In element mode (`in_mode`=0), metadata bits [1:0] give the low index i0 and bits [3:2] give the high index i1. Stored bits [7:0] go to dense element i0 and stored bits [15:8] go to dense element i1. Dense element k occupies bits [8k+7:8k].
- R3: In element mode, the two dense elements not named by legal metadata are zero, and so a legal output group never has more than two nonzero bytes.
- R4: In pair mode (`in_mode`=1), metadata bits [1:0] and [3:2] are pair indices p0 and p1, and stored nibble j occupies bits [4j+3:4j]. Nibbles 0 and 1 go to elements 2·p0 and 2·p0+1, and nibbles 2 and 3 go to elements 2·p1 and 2·p1+1. Dense element k occupies bits [4k+3:4k], and every element outside the two named pairs is zero.
- R5: Metadata is legal only when the high index is strictly greater than the low index. For an illegal group, the lane's `out_err` bit is 1 and its dense output is all zero. For a legal group, `out_err` is 0.
- R6: The mode is captured with its beat and comes back on `out_mode`. Consecutive beats may alternate modes, and each beat is expanded in its own mode.
- R7: A beat accepted while the output stage is empty appears on the output in the next cycle. With `out_ready` held high, one beat per cycle passes through.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and all outputs hold their values. Under any back-pressure, no beat is lost, duplicated or reordered.
- R9: The lanes are independent. Lane l uses input bits [16l+15:16l] and metadata bits [4l+3:4l], and produces dense bits [32l+31:32l] and `out_err[l]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Expander can take a beat |
| in_mode | input | 1 | 0 = element mode, 1 = pair mode |
| in_data | input | LANES*16 | Compressed values, one 16-bit field per lane |
| in_meta | input | LANES*4 | Two 2-bit indices per lane |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_mode | output | 1 | Mode of the output beat |
| out_data | output | LANES*32 | Dense groups, one 32-bit field per lane |
| out_err | output | LANES | Illegal-metadata flag per lane |

## Verification
Every metadata code in both lanes is driven in both modes, in all 512 combinations. This covers the six legal index pairs, the four equal pairs and the six descending pairs in each lane. Because of that, a wrong placement, a missed zero and a misjudged legality call each give a different mismatch. Modes alternate from beat to beat, which separates a mode taken with its beat from a mode that lags by one beat. The two lanes carry different data and different codes, which exposes any crossed lane. Gaps in the input and bursts of stall on the output exercise the hold and ordering rules. A directed beat after reset pins down the one-cycle latency.

// File: rtl/sparse_expand_pkg.sv
// Package: shared types and constants for the sparse operand expander.
// Assumes: index fields are 2 bits wide (four slots per group).
package sparse_expand_pkg;

    // Sparsity pattern carried with each beat.
    typedef enum logic {
        MODE_ELEM = 1'b0,   // two of four byte elements kept
        MODE_PAIR = 1'b1    // two of four nibble pairs kept
    } sparse_mode_e;

    localparam int IDX_W   = 2;            // width of one slot index
    localparam int SLOTS   = 1 << IDX_W;   // slots per dense group
    localparam int KEPT    = 2;            // slots kept per group
    localparam int META_W  = KEPT * IDX_W; // metadata bits per group

endpackage

// File: rtl/sparse_meta_check.sv
// Module: sparse_meta_check
// Splits one group's metadata into its low and high slot index and decides
// whether the pair is legal (strictly ascending).
// Assumes: metadata low field is the first kept slot, high field the second.
module sparse_meta_check
    import sparse_expand_pkg::*;
(
    input  logic [META_W-1:0] meta,
    output logic [IDX_W-1:0]  lo_idx,
    output logic [IDX_W-1:0]  hi_idx,
    output logic              legal
);

    // Field split and ordering rule.
    always_comb begin
        lo_idx = meta[IDX_W-1:0];
        hi_idx = meta[META_W-1:IDX_W];
        legal  = (hi_idx > lo_idx);
    end

endmodule

// File: rtl/sparse_lane_expand.sv
// Module: sparse_lane_expand
// Expands one compressed group into its dense form in either mode.
// Element mode places two BYTE_W values; pair mode places two pairs of
// BYTE_W/2 values, the first of each pair into the lower element.
// Illegal metadata gives an all-zero group and raises err.
// Assumes: BYTE_W is even; purely combinational.
module sparse_lane_expand
    import sparse_expand_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                    mode,
    input  logic [KEPT*BYTE_W-1:0]  cmp,
    input  logic [META_W-1:0]       meta,
    output logic [SLOTS*BYTE_W-1:0] dense,
    output logic                    err
);

    localparam int NIB_W  = BYTE_W / 2;
    localparam int NIBS   = 2 * SLOTS;
    localparam int DNS_W  = SLOTS * BYTE_W;

    logic [IDX_W-1:0] lo_idx;
    logic [IDX_W-1:0] hi_idx;
    logic             legal;
    logic [DNS_W-1:0] elem_dense;
    logic [DNS_W-1:0] pair_dense;

    sparse_meta_check i_check (
        .meta   (meta),
        .lo_idx (lo_idx),
        .hi_idx (hi_idx),
        .legal  (legal)
    );

    // Element mode: one wide value per selected slot.
    for (genvar k = 0; k < SLOTS; k++) begin : g_elem
        always_comb begin
            if (lo_idx == IDX_W'(k))
                elem_dense[k*BYTE_W +: BYTE_W] = cmp[0 +: BYTE_W];
            else if (hi_idx == IDX_W'(k))
                elem_dense[k*BYTE_W +: BYTE_W] = cmp[BYTE_W +: BYTE_W];
            else
                elem_dense[k*BYTE_W +: BYTE_W] = '0;
        end
    end

    // Pair mode: narrow element j belongs to pair j/2, half j%2.
    for (genvar j = 0; j < NIBS; j++) begin : g_pair
        localparam int PAIR = j / 2;
        localparam int HALF = j % 2;
        always_comb begin
            if (lo_idx == IDX_W'(PAIR))
                pair_dense[j*NIB_W +: NIB_W] = cmp[HALF*NIB_W +: NIB_W];
            else if (hi_idx == IDX_W'(PAIR))
                pair_dense[j*NIB_W +: NIB_W] = cmp[(2+HALF)*NIB_W +: NIB_W];
            else
                pair_dense[j*NIB_W +: NIB_W] = '0;
        end
    end

    // Mode select and illegal-metadata blanking.
    always_comb begin
        err = !legal;
        if (!legal)
            dense = '0;
        else if (sparse_mode_e'(mode) == MODE_PAIR)
            dense = pair_dense;
        else
            dense = elem_dense;
    end

endmodule

// File: rtl/sparse_out_stage.sv
// Module: sparse_out_stage
// One-entry registered stage on a valid/ready stream. It accepts a new
// payload whenever it is empty or its payload is leaving this cycle.
// Assumes: the consumer samples out_payload only while out_valid is high.
module sparse_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_payload,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_payload
);

    // Ready when the register is empty or is being drained.
    always_comb in_ready = !out_valid || out_ready;

    // Occupancy flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (in_ready)
            out_valid <= in_valid;
    end

    // Payload capture on an accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_payload <= '0;
        else if (in_valid && in_ready)
            out_payload <= in_payload;
    end

    // R8: a stalled beat stays put.
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_payload)));

    // R7: an empty stage always takes a beat.
    assert_empty_accepts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R7: an accepted beat is presented in the next cycle.
    assert_accept_presents_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

endmodule

// File: rtl/sparse_expander.sv
// Module: sparse_expander (top)
// Expands LANES compressed sparse groups per beat into dense groups, in
// element (2-of-4) or pair (2-of-4 pairs of half-width values) mode, and
// flags illegal metadata per lane. Output is registered: latency one cycle.
// Assumes: all lanes of one beat share the mode bit.
module sparse_expander
    import sparse_expand_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic                            in_mode,
    input  logic [LANES*KEPT*BYTE_W-1:0]    in_data,
    input  logic [LANES*META_W-1:0]         in_meta,
    output logic                            out_valid,
    input  logic                            out_ready,
    output logic                            out_mode,
    output logic [LANES*SLOTS*BYTE_W-1:0]   out_data,
    output logic [LANES-1:0]                out_err
);

    localparam int CMP_W = KEPT * BYTE_W;
    localparam int DNS_W = SLOTS * BYTE_W;
    localparam int PAY_W = 1 + LANES + LANES * DNS_W;

    logic [LANES*DNS_W-1:0] lane_dense;
    logic [LANES-1:0]       lane_err;
    logic [PAY_W-1:0]       stage_in;
    logic [PAY_W-1:0]       stage_out;

    // One expander per lane on its own slice.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SLOTS-1:0] slot_nz;

        sparse_lane_expand #(.BYTE_W(BYTE_W)) i_lane (
            .mode  (in_mode),
            .cmp   (in_data[l*CMP_W +: CMP_W]),
            .meta  (in_meta[l*META_W +: META_W]),
            .dense (lane_dense[l*DNS_W +: DNS_W]),
            .err   (lane_err[l])
        );

        // Nonzero flag per byte slot (a slot is also one nibble pair).
        for (genvar k = 0; k < SLOTS; k++) begin : g_nz
            always_comb slot_nz[k] = |lane_dense[l*DNS_W + k*BYTE_W +: BYTE_W];
        end

        // R3 / R4: at most two of four slots (elements or pairs) carry data.
        assert_two_slots_R3: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> ($countones(slot_nz) <= KEPT));

        // R5: a flagged lane leaves the stage as an all-zero group.
        assert_err_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_ready && lane_err[l])
            |=> (out_err[l] && (out_data[l*DNS_W +: DNS_W] == '0)));
    end

    // Pack mode, flags and dense data into the stage payload.
    always_comb stage_in = {in_mode, lane_err, lane_dense};

    sparse_out_stage #(.W(PAY_W)) i_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_payload  (stage_in),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_payload (stage_out)
    );

    // Unpack the registered payload onto the ports.
    always_comb begin
        out_mode = stage_out[PAY_W-1];
        out_err  = stage_out[LANES*DNS_W +: LANES];
        out_data = stage_out[LANES*DNS_W-1:0];
    end

    // R6: the mode presented is the mode of the beat accepted a cycle ago.
    assert_mode_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_mode == $past(in_mode)));

endmodule

// File: tb/test_sparse_expander.sv
`timescale 1ns/100ps
// Bench: sweeps every metadata code in both lanes and both modes under
// input gaps and output stalls; reference computed from the requirements.
module test_sparse_expander;

    localparam int LANES = 2;
    localparam int NBEATS = 512;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic                 in_mode = 1'b0;
    logic [LANES*16-1:0]  in_data = '0;
    logic [LANES*4-1:0]   in_meta = '0;
    logic                 out_valid;
    logic                 out_ready = 1'b0;
    logic                 out_mode;
    logic [LANES*32-1:0]  out_data;
    logic [LANES-1:0]     out_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [LANES*32-1:0] q_dense[$];
    logic [LANES-1:0]    q_err[$];
    logic                q_mode[$];

    always #2.5 clk = ~clk;

    sparse_expander #(.LANES(LANES), .BYTE_W(8)) i_sparse_expander (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_data(in_data), .in_meta(in_meta),
        .out_valid(out_valid), .out_ready(out_ready), .out_mode(out_mode),
        .out_data(out_data), .out_err(out_err)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference for one lane: bit 32 = error, bits 31:0 = dense group.
    function automatic logic [32:0] ref_lane(input logic mode,
                                             input logic [15:0] d,
                                             input logic [3:0] m);
        logic [32:0] r;
        int lo, hi;
        lo = int'(m[1:0]);
        hi = int'(m[3:2]);
        r = '0;
        if (hi <= lo) begin
            r[32] = 1'b1;
        end else if (!mode) begin
            r[lo*8 +: 8] = d[7:0];
            r[hi*8 +: 8] = d[15:8];
        end else begin
            r[(2*lo)*4   +: 4] = d[3:0];
            r[(2*lo+1)*4 +: 4] = d[7:4];
            r[(2*hi)*4   +: 4] = d[11:8];
            r[(2*hi+1)*4 +: 4] = d[15:12];
        end
        return r;
    endfunction

    function automatic logic [15:0] beat_data(input int s, input int l);
        logic [31:0] v;
        v = (s * 32'h9E37 + l * 32'h5A5B) ^ 32'h0F0F;
        return v[15:0];
    endfunction

    // Watchdog: an unfinished run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [LANES*32-1:0] exp_d;
        logic [LANES-1:0]    exp_e;
        logic [LANES*32-1:0] held_d;
        logic [LANES-1:0]    held_e;
        logic                held_m;
        bit                  prev_stall;
        bit                  took;
        int                  sent;
        int                  cyc;

        // Reset for three cycles, release away from the edge.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);

        // Directed single beat: one-cycle latency.
        @(negedge clk);
        in_valid = 1'b1;
        in_mode  = 1'b0;
        in_data  = {16'hDDCC, 16'hBBAA};
        in_meta  = {2'd2, 2'd1, 2'd3, 2'd0};
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check(out_valid == 1'b1, "R7 valid one cycle after accept", 64'(out_valid), 64'd1);
        check(out_data == {32'h00DDCC00, 32'hBB0000AA}, "R7 R2 directed data",
              64'(out_data), {32'h00DDCC00, 32'hBB0000AA});
        @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R7 drained after one beat", 64'(out_valid), 64'd0);

        // Streaming sweep: beat s -> mode s[0], lane0 meta s[4:1], lane1 meta s[8:5].
        sent = 0;
        cyc = 0;
        prev_stall = 1'b0;
        took = 1'b0;
        held_d = '0;
        held_e = '0;
        held_m = 1'b0;
        while ((sent < NBEATS) || (q_mode.size() > 0)) begin
            @(negedge clk);
            cyc++;
            out_ready = ((cyc / 5) % 3) != 0;
            if (took) in_valid = 1'b0;
            took = 1'b0;
            if (!in_valid && (sent < NBEATS) && ((cyc % 7) != 3)) begin
                logic [8:0] sv;
                sv = 9'(sent);
                in_valid = 1'b1;
                in_mode  = sv[0];
                in_meta  = {sv[8:5], sv[4:1]};
                for (int l = 0; l < LANES; l++)
                    in_data[l*16 +: 16] = beat_data(sent, l);
            end
            #1;
            // Held outputs across a stall.
            if (prev_stall) begin
                check(out_valid == 1'b1, "R8 valid held in stall", 64'(out_valid), 64'd1);
                check(out_data == held_d, "R8 data held in stall", 64'(out_data), 64'(held_d));
                check({out_mode, out_err} == {held_m, held_e}, "R8 flags held in stall",
                      64'({out_mode, out_err}), 64'({held_m, held_e}));
            end
            if (out_valid && !out_ready)
                check(in_ready == 1'b0, "R8 in_ready low in stall", 64'(in_ready), 64'd0);
            // Compare a beat leaving the block.
            if (out_valid && out_ready) begin
                if (q_mode.size() == 0) begin
                    check(1'b0, "R8 beat with empty scoreboard", 64'd1, 64'd0);
                end else begin
                    exp_d = q_dense.pop_front();
                    exp_e = q_err.pop_front();
                    check(out_mode == q_mode[0], "R6 mode echo",
                          64'(out_mode), 64'(q_mode[0]));
                    for (int l = 0; l < LANES; l++) begin
                        check(out_data[l*32 +: 32] == exp_d[l*32 +: 32],
                              q_mode[0] ? "R4 R9 pair placement" : "R2 R3 R9 element placement",
                              64'(out_data[l*32 +: 32]), 64'(exp_d[l*32 +: 32]));
                        check(out_err[l] == exp_e[l], "R5 R9 legality flag",
                              64'(out_err[l]), 64'(exp_e[l]));
                    end
                    void'(q_mode.pop_front());
                end
            end
            prev_stall = out_valid && !out_ready;
            held_d = out_data;
            held_e = out_err;
            held_m = out_mode;
            // Record a beat entering the block.
            if (in_valid && in_ready) begin
                for (int l = 0; l < LANES; l++) begin
                    logic [32:0] r;
                    r = ref_lane(in_mode, in_data[l*16 +: 16], in_meta[l*4 +: 4]);
                    exp_d[l*32 +: 32] = r[31:0];
                    exp_e[l] = r[32];
                end
                q_dense.push_back(exp_d);
                q_err.push_back(exp_e);
                q_mode.push_back(in_mode);
                sent++;
                took = 1'b1;
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule